// File: doc/BRIEF.md
# Shared-Line TDM Audio Output Port

This block takes four-channel sets of 24-bit two's-complement audio and sends them out serially, most significant bit first. In TDM mode every channel sits in a slot chosen by its own 6-bit slot number. The port drives the shared data line only while one of its own slots is on the wire. At all other bits it lowers the output enable, so the pad releases the line. Several such ports can therefore place their slots on one line without clashing. In two-line I2S-style mode the first data line carries channels 0 and 1 and the second line carries channels 2 and 3. Both lines are then driven all the time.

The bit clock and the frame sync either arrive from outside (slave mode) or are produced by the block (master mode). Slave clocks are oversampled in the `clk` domain, so they must be at least six `clk` periods long in each phase. In master mode the frame length in bits comes from a pin. The frame-sync high time is either a programmed number of bit clocks or half the frame. Samples come in over a valid/ready stream one full set per beat. A single staging register gives back-pressure: `s_ready` is low while a set waits there. The waiting set moves to the serializer at the next frame start and `s_ready` rises again. A frame that finds no set waiting sends zeros.

Top module: `tdmo_port`

## Requirements
- R1: After reset both data outputs and both output enables are 0, `s_ready` is 1, and `bclk_o` and `fs_o` are 0.
- R2: A set is accepted on a clock with `s_valid` and `s_ready` both high, and `s_ready` then stays low until the next frame start. At a frame start the waiting set is latched for the whole frame. If no set is waiting, the frame carries all-zero samples. Channel c occupies `s_data[c*24 +: 24]`.
- R3: Bits are counted on bit-clock rising edges, and bit 0 is the rising edge at which the frame sync is first seen high (TDM). Each bit is launched after that rising edge, MSB first. With `cfg_shift_left`=0 the first data bit is bit 1. With `cfg_shift_left`=1 it is bit 0.
- R4: In TDM mode, channel c with slot number s = `cfg_slots[c*6 +: 6]` sends its 24 bits on data bits 24*s to 24*s+23, counted from the first data bit, on `sd0_o`.
- R5: `sd0_oe` is high only on bits that belong to a slot of this port. It falls on the bit right after the LSB of the last slot in a run of adjacent slots. Whenever an enable is low, the matching data output is 0.
- R6: When two channels are given the same slot, the channel with the lower index is sent.
- R7: In TDM mode `sd1_oe` and `sd1_o` stay 0.
- R8: In I2S mode (`cfg_i2s`=1) every frame-sync edge starts a half-frame. Sync low sends channel 0 on `sd0_o` and channel 2 on `sd1_o`. Sync high sends channels 1 and 3. Both enables are 1, the bit 1/bit 0 rule of R3 applies, and bits after the LSB are 0. A new set is latched at the falling edge of the sync.
- R9: In master mode `bclk_o` has a period of 2*DIV_HALF `clk` cycles. `fs_o` changes only while `bclk_o` is low, and a frame is `cfg_frame_len` bit clocks long.
- R10: In master TDM mode `fs_o` stays high for `cfg_fs_high` bit clocks, or for `cfg_frame_len`/2 when `cfg_fs_half` is 1. In master I2S mode it is low for the first half of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample set valid |
| s_ready | output | 1 | Staging register empty |
| s_data | input | 96 | Four 24-bit samples, channel c at bits c*24 |
| cfg_master | input | 1 | 1: generate bit clock and frame sync |
| cfg_i2s | input | 1 | 1: two-line I2S-style mode, 0: TDM |
| cfg_shift_left | input | 1 | 1: first data bit at the frame-start edge |
| cfg_fs_half | input | 1 | Master: frame-sync high for half the frame |
| cfg_frame_len | input | 11 | Master: bits per frame |
| cfg_fs_high | input | 11 | Master: frame-sync high time in bits |
| cfg_slots | input | 24 | Four 6-bit slot numbers, channel c at bits c*6 |
| sclk_i | input | 1 | Slave bit clock |
| fs_i | input | 1 | Slave frame sync |
| bclk_o | output | 1 | Master bit clock |
| fs_o | output | 1 | Master frame sync |
| sd0_o | output | 1 | Data line 0 |
| sd0_oe | output | 1 | Drive enable for data line 0 |
| sd1_o | output | 1 | Data line 1 |
| sd1_oe | output | 1 | Drive enable for data line 1 |

## Verification
The bench checks every bit of every frame against a model. The patterns are contiguous slots, slots with gaps, slots placed in random order, and colliding slots. The contiguous and gap patterns show whether the enable drops exactly after an LSB. The colliding pattern shows whether the lower channel wins. Random slot numbers and random sync widths, run with both shift-left settings, catch an off-by-one in the bit count. An underrun frame and the I2S halves show whether the latch falls at the right sync edge and whether the lines are swapped. Master runs with a programmed sync width and with the half-frame width measure the period, the width, and the sync edge position against the bit clock.

// File: rtl/tdmo_pkg.sv
package tdmo_pkg;
  localparam int NCH = 4;

  typedef struct packed {
    logic act;
    logic pre;
    logic half;
  } tdmo_phase_t;
endpackage

// File: rtl/tdmo_bitedge.sv
module tdmo_bitedge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_gen,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic gen_rise,
  input  logic gen_fs,
  output logic rise,
  output logic fs_at
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sck_s, fs_s;
  logic sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      fs_s  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_s <= {sck_s[TOP-1:0], sclk_i};
      fs_s  <= {fs_s[TOP-1:0], fs_i};
      sck_d <= sck_s[TOP];
    end
  end

  assign rise  = use_gen ? gen_rise : (sck_s[TOP] & ~sck_d);
  assign fs_at = use_gen ? gen_fs : fs_s[TOP];
endmodule

// File: rtl/tdmo_clkgen.sv
module tdmo_clkgen #(
  parameter int DIV_HALF = 2,
  parameter int CNT_W    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i2s,
  input  logic             fs_half,
  input  logic [CNT_W-1:0] frame_len,
  input  logic [CNT_W-1:0] fs_high,
  output logic             bclk,
  output logic             fs,
  output logic             rise
);
  localparam int DC_W = $clog2(DIV_HALF) + 1;

  logic [DC_W-1:0]  dc_q;
  logic [CNT_W-1:0] bit_q, bit_n, hi_w;
  logic             bclk_q, fs_q, rise_q, wrap, fs_n;

  assign wrap  = (dc_q == DC_W'(DIV_HALF - 1));
  assign bit_n = (bit_q >= frame_len - CNT_W'(1)) ? '0 : bit_q + CNT_W'(1);
  assign hi_w  = fs_half ? (frame_len >> 1) : fs_high;
  assign fs_n  = i2s ? (bit_n >= (frame_len >> 1)) : (bit_n < hi_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q   <= '0;
      bit_q  <= '1;
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      rise_q <= 1'b0;
    end else if (!en) begin
      dc_q   <= '0;
      bit_q  <= '1;
      bclk_q <= 1'b0;
      fs_q   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= wrap && !bclk_q;
      if (wrap) begin
        dc_q   <= '0;
        bclk_q <= !bclk_q;
        if (bclk_q) begin
          bit_q <= bit_n;
          fs_q  <= fs_n;
        end
      end else begin
        dc_q <= dc_q + DC_W'(1);
      end
    end
  end

  assign bclk = bclk_q;
  assign fs   = fs_q;
  assign rise = rise_q;
endmodule

// File: rtl/tdmo_slotpick.sv
module tdmo_slotpick #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 6,
  parameter int CH_W   = 2
) (
  input  logic                  act,
  input  logic [SLOT_W-1:0]     cur,
  input  logic [NCH*SLOT_W-1:0] slots,
  output logic                  hit,
  output logic [CH_W-1:0]       pick
);
  logic [NCH-1:0] match;

  for (genvar g = 0; g < NCH; g++) begin : g_match
    assign match[g] = act && (slots[g*SLOT_W +: SLOT_W] == cur);
  end

  always_comb begin
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (match[c]) pick = CH_W'(c);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tdmo_port.sv
module tdmo_port
  import tdmo_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SLOT_W      = 6,
  parameter int CNT_W       = 11,
  parameter int DIV_HALF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [NCH*DATA_W-1:0] s_data,
  input  logic                  cfg_master,
  input  logic                  cfg_i2s,
  input  logic                  cfg_shift_left,
  input  logic                  cfg_fs_half,
  input  logic [CNT_W-1:0]      cfg_frame_len,
  input  logic [CNT_W-1:0]      cfg_fs_high,
  input  logic [NCH*SLOT_W-1:0] cfg_slots,
  input  logic                  sclk_i,
  input  logic                  fs_i,
  output logic                  bclk_o,
  output logic                  fs_o,
  output logic                  sd0_o,
  output logic                  sd0_oe,
  output logic                  sd1_o,
  output logic                  sd1_oe
);
  localparam int OFF_W = $clog2(DATA_W);
  localparam int CH_W  = $clog2(NCH);

  typedef logic [NCH-1:0][DATA_W-1:0] set_t;

  logic gen_rise, gen_fs, bit_rise, fs_at;

  tdmo_clkgen #(.DIV_HALF(DIV_HALF), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .en(cfg_master), .i2s(cfg_i2s),
    .fs_half(cfg_fs_half), .frame_len(cfg_frame_len), .fs_high(cfg_fs_high),
    .bclk(bclk_o), .fs(gen_fs), .rise(gen_rise)
  );
  assign fs_o = gen_fs;

  tdmo_bitedge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .use_gen(cfg_master), .sclk_i(sclk_i),
    .fs_i(fs_i), .gen_rise(gen_rise), .gen_fs(gen_fs),
    .rise(bit_rise), .fs_at(fs_at)
  );

  // frame start and sample latching
  set_t stage_q, shadow_q, shadow_n;
  logic full_q, fs_prev_q, start, latch;

  assign s_ready  = !full_q;
  assign start    = bit_rise && (cfg_i2s ? (fs_at != fs_prev_q) : (fs_at && !fs_prev_q));
  assign latch    = start && !(cfg_i2s && fs_at);
  assign shadow_n = latch ? (full_q ? stage_q : '0) : shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      shadow_q  <= '0;
      full_q    <= 1'b0;
      fs_prev_q <= 1'b0;
    end else begin
      if (bit_rise) fs_prev_q <= fs_at;
      shadow_q <= shadow_n;
      if (latch) full_q <= 1'b0;
      if (s_valid && !full_q) begin
        stage_q <= s_data;
        full_q  <= 1'b1;
      end
    end
  end

  // bit position within the frame
  tdmo_phase_t ph_q, ph_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [OFF_W-1:0]  off_q, off_n;

  always_comb begin
    ph_n   = ph_q;
    slot_n = slot_q;
    off_n  = off_q;
    if (start) begin
      ph_n.half = fs_at;
      if (cfg_shift_left) begin
        ph_n.act = 1'b1;
        ph_n.pre = 1'b0;
        slot_n   = '0;
        off_n    = '0;
      end else begin
        ph_n.act = 1'b0;
        ph_n.pre = 1'b1;
      end
    end else if (bit_rise) begin
      if (ph_q.pre) begin
        ph_n.act = 1'b1;
        ph_n.pre = 1'b0;
        slot_n   = '0;
        off_n    = '0;
      end else if (ph_q.act) begin
        if (off_q == OFF_W'(DATA_W - 1)) begin
          off_n = '0;
          if (&slot_q) ph_n.act = 1'b0;
          else slot_n = slot_q + SLOT_W'(1);
        end else begin
          off_n = off_q + OFF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      slot_q <= '0;
      off_q  <= '0;
    end else begin
      ph_q   <= ph_n;
      slot_q <= slot_n;
      off_q  <= off_n;
    end
  end

  // output selection
  logic             hit;
  logic [CH_W-1:0]  pick, lch, rch;
  logic [OFF_W-1:0] bsel;
  logic             d0_n, d1_n, oe0_n, oe1_n, first_slot;

  tdmo_slotpick #(.NCH(NCH), .SLOT_W(SLOT_W), .CH_W(CH_W)) u_pick (
    .act(ph_n.act), .cur(slot_n), .slots(cfg_slots), .hit(hit), .pick(pick)
  );

  assign bsel       = OFF_W'(DATA_W - 1) - off_n;
  assign lch        = ph_n.half ? CH_W'(1) : CH_W'(0);
  assign rch        = ph_n.half ? CH_W'(3) : CH_W'(2);
  assign first_slot = ph_n.act && (slot_n == '0);

  always_comb begin
    if (cfg_i2s) begin
      oe0_n = 1'b1;
      oe1_n = 1'b1;
      d0_n  = first_slot && shadow_n[lch][bsel];
      d1_n  = first_slot && shadow_n[rch][bsel];
    end else begin
      oe0_n = hit;
      d0_n  = hit && shadow_n[pick][bsel];
      oe1_n = 1'b0;
      d1_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd0_o  <= 1'b0;
      sd0_oe <= 1'b0;
      sd1_o  <= 1'b0;
      sd1_oe <= 1'b0;
    end else if (bit_rise) begin
      sd0_o  <= d0_n;
      sd0_oe <= oe0_n;
      sd1_o  <= d1_n;
      sd1_oe <= oe1_n;
    end
  end
endmodule

// File: rtl/tdmo_port_chk.sv
module tdmo_port_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             cfg_master,
  input logic             cfg_i2s,
  input logic             cfg_fs_half,
  input logic [CNT_W-1:0] cfg_frame_len,
  input logic [CNT_W-1:0] cfg_fs_high,
  input logic             bit_rise,
  input logic             fs_o,
  input logic             sd0_o,
  input logic             sd0_oe,
  input logic             sd1_o,
  input logic             sd1_oe
);
  logic [CNT_W:0] run_q;
  logic [CNT_W:0] width;

  assign width = {1'b0, (cfg_fs_half ? (cfg_frame_len >> 1) : cfg_fs_high)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bit_rise && cfg_master) run_q <= fs_o ? run_q + (CNT_W+1)'(1) : '0;
  end

  assert_quiet_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd0_oe |-> !sd0_o) and (!sd1_oe |-> !sd1_o));

  assert_line1_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i2s |-> !sd1_oe);

  assert_launch_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sd0_o) || !$stable(sd0_oe) || !$stable(sd1_o)) |-> $past(bit_rise));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ready) |-> $past(s_valid));

  assert_sync_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !cfg_i2s) |-> (run_q <= width));
endmodule

bind tdmo_port tdmo_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .cfg_master(cfg_master), .cfg_i2s(cfg_i2s), .cfg_fs_half(cfg_fs_half),
  .cfg_frame_len(cfg_frame_len), .cfg_fs_high(cfg_fs_high),
  .bit_rise(bit_rise), .fs_o(fs_o), .sd0_o(sd0_o), .sd0_oe(sd0_oe),
  .sd1_o(sd1_o), .sd1_oe(sd1_oe)
);

// File: tb/tb_tdmo_port.sv
`timescale 1ns/1ps
module tb_tdmo_port;
  localparam int DIV = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, s_valid, s_ready;
  logic [95:0] s_data;
  logic cfg_master, cfg_i2s, cfg_shift_left, cfg_fs_half;
  logic [10:0] cfg_frame_len, cfg_fs_high;
  logic [23:0] cfg_slots;
  logic sclk_i, fs_i, bclk_o, fs_o, sd0_o, sd0_oe, sd1_o, sd1_oe;

  tdmo_port dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cfg_master(cfg_master), .cfg_i2s(cfg_i2s), .cfg_shift_left(cfg_shift_left),
    .cfg_fs_half(cfg_fs_half), .cfg_frame_len(cfg_frame_len), .cfg_fs_high(cfg_fs_high),
    .cfg_slots(cfg_slots), .sclk_i(sclk_i), .fs_i(fs_i), .bclk_o(bclk_o), .fs_o(fs_o),
    .sd0_o(sd0_o), .sd0_oe(sd0_oe), .sd1_o(sd1_o), .sd1_oe(sd1_oe)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual={oe1,d1,oe0,d0}=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] obs();
    return {sd1_oe, sd1_o, sd0_oe, sd0_o};
  endfunction

  // returns {oe1,d1,oe0,d0} for bit n counted from the frame/half start
  function automatic logic [3:0] expect_bits(input logic i2s, input logic shl, input logic half,
                                             input logic [23:0] slots, input logic [95:0] set,
                                             input int n);
    logic [3:0] r;
    int b, sl, of, ch;
    r = 4'b0000;
    b = shl ? n : n - 1;
    if (i2s) begin
      r[1] = 1'b1;
      r[3] = 1'b1;
      if (b >= 0 && b < 24) begin
        r[0] = set[(half ? 1 : 0)*24 + 23 - b];
        r[2] = set[(half ? 3 : 2)*24 + 23 - b];
      end
    end else if (b >= 0) begin
      sl = b / 24;
      of = b % 24;
      ch = -1;
      for (int c = 3; c >= 0; c--) if (int'(slots[c*6 +: 6]) == sl) ch = c;
      if (ch >= 0) begin
        r[1] = 1'b1;
        r[0] = set[ch*24 + 23 - of];
      end
    end
    return r;
  endfunction

  function automatic logic [95:0] rnd_set();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    s_valid = 1'b0;
    sclk_i = 1'b0;
    fs_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(input logic [95:0] set);
    @(negedge clk);
    s_data = set;
    s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic bit_cycle(input logic fsv);
    fs_i = fsv;
    sclk_i = 1'b0;
    repeat (6) @(negedge clk);
    sclk_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic tdm_frame(input logic shl, input logic [23:0] slots, input logic [95:0] set,
                           input int nbits, input int fsw, input string tag);
    cfg_shift_left = shl;
    cfg_slots = slots;
    for (int n = 0; n < nbits; n++) begin
      bit_cycle(n < fsw);
      chk4(tag, obs(), expect_bits(1'b0, shl, 1'b0, slots, set, n));
    end
  endtask

  task automatic i2s_half(input logic half, input logic [95:0] set, input int nbits);
    for (int n = 0; n < nbits; n++) begin
      bit_cycle(half);
      chk4("R8 i2s lines", obs(), expect_bits(1'b1, 1'b0, half, 24'h0, set, n));
    end
  endtask

  task automatic master_run(input int ncyc, input logic [95:0] set0, input logic shl,
                            input logic [23:0] slots, input int flen, input int expw);
    logic pb, pf, pfr, seen;
    int since, n, frames, wcnt;
    logic [95:0] cur;
    pb = 1'b0; pf = 1'b0; pfr = 1'b0; seen = 1'b0;
    since = 0; n = 0; frames = 0; wcnt = 0;
    repeat (ncyc) begin
      @(negedge clk);
      since++;
      if (fs_o !== pf) chkv("R9 sync moves while bit clock low", int'(bclk_o), 0);
      if (bclk_o && !pb) begin
        if (seen) chkv("R9 bit clock period", since, 2*DIV);
        seen = 1'b1;
        since = 0;
        if (fs_o && !pfr) begin
          if (frames > 0) begin
            chkv("R10 sync high width", wcnt, expw);
            chkv("R9 frame length", n + 1, flen);
          end
          frames++;
          n = 0;
          wcnt = 0;
        end else begin
          n++;
        end
        if (fs_o) wcnt++;
        pfr = fs_o;
      end
      if (!bclk_o && pb && frames > 0) begin
        cur = (frames == 1) ? set0 : 96'h0;
        chk4("R4 master data", obs(), expect_bits(1'b0, shl, 1'b0, slots, cur, n));
      end
      pb = bclk_o;
      pf = fs_o;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [95:0] a;
    void'($urandom(32'h51A7_0C3D));
    s_data = '0;
    cfg_master = 1'b0; cfg_i2s = 1'b0; cfg_shift_left = 1'b0; cfg_fs_half = 1'b0;
    cfg_frame_len = 11'd64; cfg_fs_high = 11'd1; cfg_slots = 24'h0;
    do_reset();

    // R1 reset state
    chk4("R1 data lines after reset", obs(), 4'b0000);
    chkv("R1 ready after reset", int'(s_ready), 1);
    chkv("R1 clocks after reset", int'({bclk_o, fs_o}), 0);

    // R2 back-pressure, R3/R4/R5 contiguous slots, delayed start
    a = rnd_set();
    push(a);
    chkv("R2 ready low while set waits", int'(s_ready), 0);
    tdm_frame(1'b0, {6'd3, 6'd2, 6'd1, 6'd0}, a, 24*8 + 2, 1, "R3 R4 R5 contiguous");
    chkv("R2 ready back after frame start", int'(s_ready), 1);

    // gaps, shift-left
    a = rnd_set();
    push(a);
    tdm_frame(1'b1, {6'd1, 6'd5, 6'd0, 6'd3}, a, 24*8 + 2, 3, "R3 R5 R7 gaps shift-left");

    // R6 collisions
    a = rnd_set();
    push(a);
    tdm_frame(1'b0, {6'd4, 6'd4, 6'd2, 6'd2}, a, 24*8 + 2, 2, "R6 shared slots");

    // randomized frames
    for (int k = 0; k < 6; k++) begin
      logic [23:0] sl;
      a = rnd_set();
      sl = {6'($urandom % 8), 6'($urandom % 8), 6'($urandom % 8), 6'($urandom % 8)};
      push(a);
      tdm_frame(1'($urandom % 2), sl, a, 24*8 + 2, 1 + int'($urandom % 20), "R4 R5 random slots");
    end

    // R2 underrun: no set pushed
    tdm_frame(1'b0, {6'd6, 6'd4, 6'd1, 6'd0}, 96'h0, 24*8 + 2, 1, "R2 underrun zeros");

    // R8 I2S slave
    do_reset();
    cfg_i2s = 1'b1;
    cfg_shift_left = 1'b0;
    for (int n = 0; n < 4; n++) bit_cycle(1'b1);
    for (int k = 0; k < 2; k++) begin
      a = rnd_set();
      push(a);
      i2s_half(1'b0, a, 32);
      i2s_half(1'b1, a, 32);
    end

    // R9 R10 master, programmed width
    cfg_i2s = 1'b0;
    do_reset();
    cfg_frame_len = 11'd64;
    cfg_fs_high = 11'd3;
    cfg_fs_half = 1'b0;
    cfg_shift_left = 1'b0;
    cfg_slots = {6'd63, 6'd63, 6'd1, 6'd0};
    a = rnd_set();
    push(a);
    cfg_master = 1'b1;
    master_run(64*2*DIV*3 + 40, a, 1'b0, cfg_slots, 64, 3);

    // R10 master, half-frame width
    cfg_master = 1'b0;
    do_reset();
    cfg_frame_len = 11'd48;
    cfg_fs_half = 1'b1;
    cfg_shift_left = 1'b1;
    cfg_slots = {6'd63, 6'd63, 6'd63, 6'd0};
    a = rnd_set();
    push(a);
    cfg_master = 1'b1;
    master_run(48*2*DIV*3 + 40, a, 1'b1, cfg_slots, 48, 24);

    finish_run();
  end
endmodule